// File: doc/BRIEF.md
# Interrupt Acknowledge Vector and Cascade Sequencer

This block answers the processor's interrupt-acknowledge handshake for an interrupt controller. A separate priority resolver supplies the winning level number and a valid flag. The sequencer counts the active-low acknowledge pulses and decides, pulse by pulse, whether this chip drives a byte on the 8-bit data bus and which byte that is. It also decides what happens on the 3-bit cascade bus.

Two response formats are supported. In vector mode the sequence has two pulses, and a single vector number is returned on the second pulse. In CALL mode the sequence has three pulses, and the block returns a CALL opcode followed by the two bytes of a service-routine address.

Chips can be chained in a master/slave arrangement:
- A master that finds a slave attached to the winning level publishes that level on the cascade bus as the slave ID.
- A slave answers only when the ID on the cascade bus equals its own programmed ID.
- The role comes from a strap input, or from a configuration bit when the block works with external data buffers.

The tristate data bus is modelled as a value plus an output enable. The cascade bus is modelled the same way.

Top module: `intack_seq_top`

## Requirements
- R1: After synchronous reset, `dout_oe`, `cas_oe` and `buf_en` are low and `dout` is zero.
- R2: A pulse starts when `ack_n` is sampled low after being sampled high. When the block responds to a pulse, `dout_oe` rises one cycle after that low sample. `dout_oe` falls one cycle after `ack_n` is sampled high again. Outside a responding pulse, `dout_oe` is low and `dout` is zero.
- R3: In vector mode (`call_mode`=0) a sequence is two pulses long. Pulse 1 drives no data. Pulse 2 drives `{vec_base[7:3], level}`, where level is the 3-bit level number.
- R4: In CALL mode (`call_mode`=1) a sequence is three pulses long, with one byte per pulse:
  - pulse 1: opcode 0xCD;
  - pulse 2: `(addr_lo + level*S) mod 256`, where S is 4 when `wide_interval`=0 and 8 when it is 1;
  - pulse 3: `addr_hi`.
- R5: A master whose winning level has its `slave_map[level]` bit set behaves as follows:
  - it raises `cas_oe` with `cas_out`=level one cycle after the start of pulse 1;
  - it holds both until one cycle after the final pulse is released;
  - it drives no vector or address byte, but in CALL mode it still drives the opcode on pulse 1.
- R6: A slave behaves as follows:
  - it compares `cas_in` with `own_id` at the start of pulse 2;
  - on a match it drives the pulse-2 byte, and in CALL mode also the pulse-3 byte, using the R3/R4 formats and its own captured level;
  - it never drives pulse 1 and never raises `cas_oe`.
- R7: A slave whose `own_id` differs from `cas_in` keeps `dout_oe` low for the whole sequence.
- R8: Role selection depends on `buffered`:
  - With `buffered`=0, `strap`=1 selects master and `strap`=0 selects slave, and `buf_en` stays low.
  - With `buffered`=1, `buf_master` selects the role, `strap` is ignored, and `buf_en` follows `dout_oe`.
- R9: The level and `call_mode` are captured at the start of pulse 1. Later changes to them have no effect until the sequence ends.
- R10: If `req_valid` is low at the start of pulse 1, level 7 is used for the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_n | input | 1 | Acknowledge pulse from the processor, active low |
| req_valid | input | 1 | Priority resolver has a winning level |
| req_level | input | 3 | Winning level number |
| call_mode | input | 1 | 1: three-byte CALL response; 0: single vector |
| vec_base | input | 8 | Vector base; upper 5 bits are used |
| addr_lo | input | 8 | Low byte of the service-routine table base |
| addr_hi | input | 8 | High byte of the service-routine address |
| wide_interval | input | 1 | Table spacing: 0 gives 4 bytes, 1 gives 8 bytes |
| slave_map | input | 8 | Master: levels that have a slave attached |
| own_id | input | 3 | Slave: programmed cascade ID |
| buffered | input | 1 | Buffered-bus configuration |
| buf_master | input | 1 | Role used in the buffered configuration (1 = master) |
| strap | input | 1 | Role strap used in the non-buffered configuration (1 = master) |
| cas_in | input | 3 | Cascade ID seen on the bus |
| cas_out | output | 3 | Cascade ID driven by a master |
| cas_oe | output | 1 | Cascade bus output enable |
| dout | output | 8 | Response byte |
| dout_oe | output | 1 | Data bus output enable; low means high impedance |
| buf_en | output | 1 | External data buffer enable |

## Verification
Every response appears one clock after the edge that first samples `ack_n` low, and `cas_oe` follows the same rule. Every release appears one clock after the edge that first samples `ack_n` high. The cascade enable drops only after the release of the final pulse.

The bench changes `ack_n` on a falling clock edge, so exactly one rising edge lies between the change and the next falling edge. It compares the outputs at that next falling edge, against an expected item it queued when it drove the pulse. It also checks after the release, so that each expected value is tied to the single register stage between `ack_n` and the outputs.

// File: rtl/intack_pkg.sv
// Shared types and constants for the interrupt-acknowledge sequencer.
// Assumes at most three acknowledge pulses per sequence.
package intack_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_THIRD  = 2'd3
    } ack_ph_t;

    localparam logic [7:0] INTACK_CALL_OP = 8'hCD;

    // Role selection: buffered configurations take the role from a config bit.
    function automatic logic resolve_master(input logic buffered,
                                            input logic buf_master,
                                            input logic strap);
        return buffered ? buf_master : strap;
    endfunction

endpackage

// File: rtl/intack_pulse_tracker.sv
// Counts acknowledge pulses and reports start/end events and the pulse index.
// Assumes ack_n is already synchronous to clk; the mode is latched on pulse 1.
module intack_pulse_tracker
    import intack_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ack_n,
    input  logic    call_mode,
    output logic    start_o,
    output logic    end_o,
    output ack_ph_t start_ph_o,
    output logic    start_mode_o,
    output ack_ph_t phase_o,
    output logic    mode_o,
    output logic    seq_done_o
);

    logic    ack_prev;
    ack_ph_t phase_q;
    logic    mode_q;
    ack_ph_t last_ph;

    // Edge detection on the sampled acknowledge level.
    always_comb begin
        start_o = ack_prev & ~ack_n;
        end_o   = ~ack_prev & ack_n;
    end

    // Index and mode seen by the pulse that starts now.
    always_comb begin
        start_ph_o   = ack_ph_t'(2'(phase_q) + 2'd1);
        start_mode_o = (phase_q == PH_IDLE) ? call_mode : mode_q;
        last_ph      = mode_q ? PH_THIRD : PH_SECOND;
        seq_done_o   = end_o & (phase_q == last_ph);
    end

    // Previous acknowledge sample; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev <= 1'b1;
        else        ack_prev <= ack_n;
    end

    // Pulse index and latched mode for the running sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mode_q  <= 1'b0;
        end else if (start_o) begin
            phase_q <= start_ph_o;
            if (phase_q == PH_IDLE) mode_q <= call_mode;
        end else if (seq_done_o) begin
            phase_q <= PH_IDLE;
        end
    end

    assign phase_o = phase_q;
    assign mode_o  = mode_q;

endmodule

// File: rtl/intack_cascade.sv
// Cascade bus handling: a master publishes the slave ID, a slave matches it.
// Assumes the master's ID is stable on cas_in by the start of pulse 2.
module intack_cascade
    import intack_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    localparam int ID_W = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  is_master,
    input  logic                  start,
    input  ack_ph_t               start_ph,
    input  logic                  seq_done,
    input  logic [ID_W-1:0]       level_now,
    input  logic [NUM_LEVELS-1:0] slave_map,
    input  logic [ID_W-1:0]       cas_in,
    input  logic [ID_W-1:0]       own_id,
    output logic                  attached_now,
    output logic                  matched_now,
    output logic [ID_W-1:0]       cas_out,
    output logic                  cas_oe
);

    logic            attached_q;
    logic            matched_q;
    logic [ID_W-1:0] eq_bits;
    logic            id_equal;

    // Bitwise ID comparator.
    for (genvar i = 0; i < ID_W; i++) begin : g_cmp
        assign eq_bits[i] = ~(cas_in[i] ^ own_id[i]);
    end
    assign id_equal = &eq_bits;

    // Current-sequence view, using live values on the deciding pulse.
    always_comb begin
        attached_now = (start_ph == PH_FIRST)  ? slave_map[level_now] : attached_q;
        matched_now  = (start_ph == PH_SECOND) ? id_equal             : matched_q;
    end

    // Sequence-wide attach and match flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attached_q <= 1'b0;
            matched_q  <= 1'b0;
        end else if (start && start_ph == PH_FIRST) begin
            attached_q <= slave_map[level_now];
            matched_q  <= 1'b0;
        end else if (start && start_ph == PH_SECOND) begin
            matched_q  <= id_equal;
        end else if (seq_done) begin
            attached_q <= 1'b0;
            matched_q  <= 1'b0;
        end
    end

    // Master drive of the cascade ID for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_oe  <= 1'b0;
            cas_out <= '0;
        end else if (start && start_ph == PH_FIRST) begin
            cas_oe  <= is_master & slave_map[level_now];
            cas_out <= level_now;
        end else if (seq_done) begin
            cas_oe  <= 1'b0;
        end
    end

endmodule

// File: rtl/intack_composer.sv
// Combinational byte composer: decides whether this chip drives a pulse and what.
// Assumes DW exceeds ID_W and the level fits in ID_W bits.
module intack_composer
    import intack_pkg::*;
#(
    parameter int         DW           = 8,
    parameter int         ID_W         = 3,
    parameter int         FINE_SHIFT   = 2,
    parameter int         COARSE_SHIFT = 3,
    parameter logic [7:0] CALL_OP      = INTACK_CALL_OP
) (
    input  ack_ph_t         ph,
    input  logic            call_mode,
    input  logic [ID_W-1:0] level,
    input  logic            is_master,
    input  logic            attached,
    input  logic            matched,
    input  logic [DW-1:0]   vec_base,
    input  logic [DW-1:0]   addr_lo,
    input  logic [DW-1:0]   addr_hi,
    input  logic            wide_interval,
    output logic            drive,
    output logic [DW-1:0]   byte_val
);

    logic          owner;
    logic [DW-1:0] lvl_ext;
    logic [DW-1:0] offset;

    // Who owns the vector/address bytes of this sequence.
    always_comb begin
        owner   = (is_master & ~attached) | (~is_master & matched);
        lvl_ext = DW'(level);
        offset  = wide_interval ? (lvl_ext << COARSE_SHIFT) : (lvl_ext << FINE_SHIFT);
    end

    // Per-pulse byte selection.
    always_comb begin
        drive    = 1'b0;
        byte_val = '0;
        if (call_mode) begin
            unique case (ph)
                PH_FIRST:  begin drive = is_master; byte_val = DW'(CALL_OP); end
                PH_SECOND: begin drive = owner;     byte_val = addr_lo + offset; end
                PH_THIRD:  begin drive = owner;     byte_val = addr_hi; end
                default:   begin drive = 1'b0;      byte_val = '0; end
            endcase
        end else if (ph == PH_SECOND) begin
            drive    = owner;
            byte_val = {vec_base[DW-1:ID_W], level};
        end
    end

endmodule

// File: rtl/intack_seq_top.sv
// Interrupt-acknowledge sequencer top: resolves the role, captures the level,
// and registers the data-bus response. Assumes synchronous acknowledge input.
module intack_seq_top
    import intack_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    parameter int DW         = 8,
    localparam int ID_W = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack_n,
    input  logic                  req_valid,
    input  logic [ID_W-1:0]       req_level,
    input  logic                  call_mode,
    input  logic [DW-1:0]         vec_base,
    input  logic [DW-1:0]         addr_lo,
    input  logic [DW-1:0]         addr_hi,
    input  logic                  wide_interval,
    input  logic [NUM_LEVELS-1:0] slave_map,
    input  logic [ID_W-1:0]       own_id,
    input  logic                  buffered,
    input  logic                  buf_master,
    input  logic                  strap,
    input  logic [ID_W-1:0]       cas_in,
    output logic [ID_W-1:0]       cas_out,
    output logic                  cas_oe,
    output logic [DW-1:0]         dout,
    output logic                  dout_oe,
    output logic                  buf_en
);

    logic            master_role;
    logic            pulse_start;
    logic            pulse_end;
    ack_ph_t         start_ph;
    logic            start_mode;
    ack_ph_t         phase_q;
    logic            mode_q;
    logic            seq_done;
    logic [ID_W-1:0] lvl_q;
    logic [ID_W-1:0] lvl_eff;
    logic [ID_W-1:0] lvl_use;
    logic            attached_now;
    logic            matched_now;
    logic            drive;
    logic [DW-1:0]   byte_val;

    // Role and level selection for the pulse that starts now.
    always_comb begin
        master_role = resolve_master(buffered, buf_master, strap);
        lvl_eff     = req_valid ? req_level : ID_W'(NUM_LEVELS - 1);
        lvl_use     = (start_ph == PH_FIRST) ? lvl_eff : lvl_q;
    end

    intack_pulse_tracker u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_n        (ack_n),
        .call_mode    (call_mode),
        .start_o      (pulse_start),
        .end_o        (pulse_end),
        .start_ph_o   (start_ph),
        .start_mode_o (start_mode),
        .phase_o      (phase_q),
        .mode_o       (mode_q),
        .seq_done_o   (seq_done)
    );

    intack_cascade #(.NUM_LEVELS(NUM_LEVELS)) u_cas (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_master    (master_role),
        .start        (pulse_start),
        .start_ph     (start_ph),
        .seq_done     (seq_done),
        .level_now    (lvl_use),
        .slave_map    (slave_map),
        .cas_in       (cas_in),
        .own_id       (own_id),
        .attached_now (attached_now),
        .matched_now  (matched_now),
        .cas_out      (cas_out),
        .cas_oe       (cas_oe)
    );

    intack_composer #(.DW(DW), .ID_W(ID_W)) u_comp (
        .ph            (start_ph),
        .call_mode     (start_mode),
        .level         (lvl_use),
        .is_master     (master_role),
        .attached      (attached_now),
        .matched       (matched_now),
        .vec_base      (vec_base),
        .addr_lo       (addr_lo),
        .addr_hi       (addr_hi),
        .wide_interval (wide_interval),
        .drive         (drive),
        .byte_val      (byte_val)
    );

    // Level capture on the first pulse of a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 lvl_q <= '0;
        else if (pulse_start && start_ph == PH_FIRST) lvl_q <= lvl_eff;
    end

    // Registered data-bus response and buffer enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_oe <= 1'b0;
            dout    <= '0;
            buf_en  <= 1'b0;
        end else if (pulse_start) begin
            dout_oe <= drive;
            dout    <= drive ? byte_val : '0;
            buf_en  <= drive & buffered;
        end else if (pulse_end) begin
            dout_oe <= 1'b0;
            dout    <= '0;
            buf_en  <= 1'b0;
        end
    end

endmodule

// File: rtl/intack_seq_checker.sv
// Property checker for the acknowledge sequencer, attached by bind.
module intack_seq_checker #(
    parameter int ID_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack_n,
    input logic            dout_oe,
    input logic            cas_oe,
    input logic [ID_W-1:0] cas_out,
    input logic            buf_en,
    input logic            buffered,
    input logic            master_role,
    input logic [1:0]      phase_q,
    input logic            mode_q
);

    // R2: the enable rises only one cycle after a high-to-low acknowledge sample.
    p_rise_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> (!$past(ack_n) && $past(ack_n, 2)));

    // R2: a high acknowledge sample always releases the bus on the next cycle.
    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_n) |-> !dout_oe);

    // R3: a vector-mode sequence never reaches a third pulse.
    p_vec_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (phase_q != 2'd3));

    // R5: only a master starts driving the cascade bus.
    p_cas_from_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_oe) |-> $past(master_role));

    // R5: the published ID stays stable while driven.
    p_cas_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_oe && $past(cas_oe)) |-> $stable(cas_out));

    // R6: a slave never answers the first pulse.
    p_slave_silent_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_oe) && !$past(master_role)) |-> (phase_q != 2'd1));

    // R8: the buffer enable is seen only while driving in the buffered configuration.
    p_buf_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en |-> (dout_oe && buffered));

endmodule

bind intack_seq_top intack_seq_checker #(.ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_n       (ack_n),
    .dout_oe     (dout_oe),
    .cas_oe      (cas_oe),
    .cas_out     (cas_out),
    .buf_en      (buf_en),
    .buffered    (buffered),
    .master_role (master_role),
    .phase_q     (phase_q),
    .mode_q      (mode_q)
);

// File: tb/intack_seq_top_tb.sv
// Scoreboard bench: pulse tasks queue expected outputs, a monitor compares them.
module intack_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_n = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_level = '0;
    logic       call_mode = 1'b0;
    logic [7:0] vec_base = '0;
    logic [7:0] addr_lo = '0;
    logic [7:0] addr_hi = '0;
    logic       wide_interval = 1'b0;
    logic [7:0] slave_map = '0;
    logic [2:0] own_id = '0;
    logic       buffered = 1'b0;
    logic       buf_master = 1'b0;
    logic       strap = 1'b1;
    logic [2:0] cas_in = '0;
    logic [2:0] cas_out;
    logic       cas_oe;
    logic [7:0] dout;
    logic       dout_oe;
    logic       buf_en;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    typedef struct {
        logic       oe;
        logic [7:0] d;
        logic       coe;
        logic [2:0] cas;
        logic       be;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #10 clk = ~clk;

    intack_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .req_valid(req_valid),
        .req_level(req_level), .call_mode(call_mode), .vec_base(vec_base),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .wide_interval(wide_interval),
        .slave_map(slave_map), .own_id(own_id), .buffered(buffered),
        .buf_master(buf_master), .strap(strap), .cas_in(cas_in),
        .cas_out(cas_out), .cas_oe(cas_oe), .dout(dout), .dout_oe(dout_oe),
        .buf_en(buf_en)
    );

    // Monitor: pop one expected item per sample event and compare.
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (dout_oe !== e.oe || dout !== e.d || cas_oe !== e.coe ||
                    buf_en !== e.be || (e.coe && cas_out !== e.cas)) begin
                    n_bad++;
                    $display("FAIL %s: got oe=%0b d=%02h coe=%0b cas=%0d be=%0b exp oe=%0b d=%02h coe=%0b cas=%0d be=%0b",
                             e.tag, dout_oe, dout, cas_oe, cas_out, buf_en,
                             e.oe, e.d, e.coe, e.cas, e.be);
                end
            end
        end
    end

    function automatic logic [7:0] exp_lo(input logic [7:0] base, input logic [2:0] lvl,
                                          input logic wide);
        return base + 8'(lvl) * (wide ? 8'd8 : 8'd4);
    endfunction

    task automatic push_and_sample(input logic oe, input logic [7:0] d, input logic coe,
                                   input logic [2:0] cas, input string tag);
        exp_t e;
        e.oe = oe; e.d = oe ? d : 8'h00; e.coe = coe; e.cas = cas;
        e.be = oe & buffered; e.tag = tag;
        exp_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    // One acknowledge pulse; called at a falling clock edge.
    task automatic pulse(input logic oe, input logic [7:0] d, input logic coe,
                         input logic [2:0] cas, input logic last, input string tag);
        ack_n = 1'b0;
        @(negedge clk);
        push_and_sample(oe, d, coe, cas, tag);
        repeat (2) @(negedge clk);
        ack_n = 1'b1;
        @(negedge clk);
        push_and_sample(1'b0, 8'h00, last ? 1'b0 : coe, cas, {tag, " release"});
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        push_and_sample(1'b0, 8'h00, 1'b0, 3'd0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R2: standalone master, vector mode, level 5.
        strap = 1'b1; vec_base = 8'h40; req_valid = 1'b1; req_level = 3'd5;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R3 vec pulse1 silent");
        pulse(1'b1, 8'h45, 1'b0, 3'd0, 1'b1, "R3 R2 vec pulse2");

        // R4: CALL mode, spacing 4, level 3.
        call_mode = 1'b1; addr_lo = 8'h10; addr_hi = 8'h20; req_level = 3'd3;
        pulse(1'b1, 8'hCD, 1'b0, 3'd0, 1'b0, "R4 call opcode");
        pulse(1'b1, exp_lo(8'h10, 3'd3, 1'b0), 1'b0, 3'd0, 1'b0, "R4 call low");
        pulse(1'b1, 8'h20, 1'b0, 3'd0, 1'b1, "R4 call high");

        // R4: spacing 8, level 6, low byte wraps.
        wide_interval = 1'b1; addr_lo = 8'hF0; addr_hi = 8'h33; req_level = 3'd6;
        pulse(1'b1, 8'hCD, 1'b0, 3'd0, 1'b0, "R4 wide opcode");
        pulse(1'b1, exp_lo(8'hF0, 3'd6, 1'b1), 1'b0, 3'd0, 1'b0, "R4 wide low wrap");
        pulse(1'b1, 8'h33, 1'b0, 3'd0, 1'b1, "R4 wide high");
        wide_interval = 1'b0;

        // R5: master with a slave on level 2, vector mode.
        call_mode = 1'b0; slave_map = 8'h04; req_level = 3'd2;
        pulse(1'b0, 8'h00, 1'b1, 3'd2, 1'b0, "R5 master cas p1");
        pulse(1'b0, 8'h00, 1'b1, 3'd2, 1'b1, "R5 master cas p2");

        // R5: same in CALL mode: opcode still driven by the master.
        call_mode = 1'b1;
        pulse(1'b1, 8'hCD, 1'b1, 3'd2, 1'b0, "R5 master call op");
        pulse(1'b0, 8'h00, 1'b1, 3'd2, 1'b0, "R5 master call p2");
        pulse(1'b0, 8'h00, 1'b1, 3'd2, 1'b1, "R5 master call p3");
        slave_map = 8'h00;

        // R6: matched slave, vector mode, level 1.
        strap = 1'b0; own_id = 3'd4; cas_in = 3'd4; call_mode = 1'b0;
        vec_base = 8'h88; req_level = 3'd1;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R6 slave p1 silent");
        pulse(1'b1, 8'h89, 1'b0, 3'd0, 1'b1, "R6 slave vector");

        // R6: matched slave, CALL mode, level 7.
        call_mode = 1'b1; addr_lo = 8'h00; addr_hi = 8'h5A; req_level = 3'd7;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R6 slave call p1");
        pulse(1'b1, exp_lo(8'h00, 3'd7, 1'b0), 1'b0, 3'd0, 1'b0, "R6 slave call low");
        pulse(1'b1, 8'h5A, 1'b0, 3'd0, 1'b1, "R6 slave call high");

        // R7: unmatched slave in both modes.
        cas_in = 3'd3;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R7 nomatch call p1");
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R7 nomatch call p2");
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b1, "R7 nomatch call p3");
        call_mode = 1'b0;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R7 nomatch vec p1");
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b1, "R7 nomatch vec p2");

        // R8: buffered, role from buf_master while strap says slave.
        buffered = 1'b1; buf_master = 1'b1; strap = 1'b0; vec_base = 8'hA0; req_level = 3'd0;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R8 buffered p1");
        pulse(1'b1, 8'hA0, 1'b0, 3'd0, 1'b1, "R8 buffered master buf_en");
        // R8: buffered slave, strap high ignored, ID mismatch keeps silence.
        buf_master = 1'b0; strap = 1'b1; cas_in = 3'd5;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R8 strap ignored p1");
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b1, "R8 strap ignored p2");
        buffered = 1'b0;

        // R10: no valid request at pulse 1 gives level 7.
        strap = 1'b1; vec_base = 8'h40; req_valid = 1'b0; req_level = 3'd2;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R10 novalid p1");
        pulse(1'b1, 8'h47, 1'b0, 3'd0, 1'b1, "R10 novalid vector");

        // R9: mode and level changes after pulse 1 have no effect.
        req_valid = 1'b1; req_level = 3'd5; call_mode = 1'b0;
        pulse(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, "R9 capture p1");
        call_mode = 1'b1; req_level = 3'd1;
        pulse(1'b1, 8'h45, 1'b0, 3'd0, 1'b1, "R9 captured level and mode");
        addr_lo = 8'h40; addr_hi = 8'h77;
        pulse(1'b1, 8'hCD, 1'b0, 3'd0, 1'b0, "R9 new sequence opcode");
        pulse(1'b1, exp_lo(8'h40, 3'd1, 1'b0), 1'b0, 3'd0, 1'b0, "R9 new sequence low");
        pulse(1'b1, 8'h77, 1'b0, 3'd0, 1'b1, "R9 new sequence high");

        #5;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule